// File: doc/BRIEF.md
# Six-Stage In-Order Pipelined Core

This block is a small processor core that runs a four-operation instruction set (subtract, branch on equal, load word and store word) through six pipeline stages: fetch, decode, operand read, execute, memory access and writeback. Every instruction is one 16-bit word. The fetch address starts at zero after reset and steps by two.

The core has no forwarding paths and no branch prediction. An instruction that needs a register still being produced waits in the operand-read stage, and bubbles go into execute until the producer reaches writeback. The register file passes a value written in a cycle straight to a read of the same register in that cycle. A branch stops fetch as soon as it is decoded. Fetch restarts in the cycle the branch is in execute, at either the target or the next sequential address.

The core connects to a combinational instruction memory and a combinational data memory. Debug outputs show the fetch address and, for each stage, the instruction word it holds and whether that word is valid.

Top module: `sixstage_core`

## Requirements
- R1: An instruction word carries the opcode in bits [15:14], rs in [13:11], rt in [10:8], rd in [7:5] and an 8-bit immediate in [7:0]. Opcode 00 is subtract: rd receives rs minus rt. The word 0x0000 has no effect.
- R2: Opcode 10 is load: rt receives the data-memory word at the address rs plus the sign-extended immediate. The data memory is word-addressed.
- R3: Opcode 11 is store. It writes the value of rt to the address rs plus the sign-extended immediate. The write strobe is high in exactly one cycle, which is cycle f+4 for an instruction fetched in cycle f that is not delayed.
- R4: Each instruction advances one stage per clock. After reset the fetch addresses are 0, 2, 4 and so on, one fetch per cycle, while nothing holds the pipeline.
- R5: With no forwarding, an instruction is held in operand read until each producer of a register it reads has reached writeback. A value written in writeback is seen by a read in the same cycle. A consumer directly behind its producer loses 2 cycles, a consumer one slot behind loses 1 cycle, and a consumer two slots behind loses none.
- R6: A store reads both rs (address base) and rt (data), and either one can cause a hold. A load reads only rs.
- R7: Register 0 always reads as zero. A write to register 0 is dropped and never causes a hold.
- R8: Opcode 01 is branch if rs equals rt. When taken, the next fetch is at the branch address plus 2 plus the sign-extended immediate, in bytes. When not taken, the next fetch is at the branch address plus 2. No fetch happens while the branch is in decode or operand read, and fetch restarts in the cycle the branch is in execute.
- R9: While reset is low, the fetch address is 0, stages decode through writeback are empty, and no store strobe is raised.
- R10: dbg_pc shows the current fetch address. dbg_stage_valid and dbg_stage_instr show, from bit 0 upward, fetch, decode, operand read, execute, memory and writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| imem_addr | output | PC_W | Instruction fetch byte address |
| imem_rdata | input | 16 | Instruction word at imem_addr |
| dmem_addr | output | DATA_W | Data memory word address |
| dmem_wdata | output | DATA_W | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | DATA_W | Data word at dmem_addr |
| dbg_pc | output | PC_W | Current fetch address |
| dbg_stage_valid | output | 6 | Valid flag of each stage, fetch in bit 0 |
| dbg_stage_instr | output | 96 | Instruction word of each stage, fetch in bits [15:0] |

## Verification
Two functions share a cycle here: the writeback of a register, and the operand read of a held instruction that needs that same register. Back-to-back and one-slot-apart producer and consumer pairs provoke this. The bench judges it by the store address, the store data and the exact cycle of the store strobe, compared with timings worked out from the hold rules. Branches whose condition depends on a just-loaded register make a hold and a branch redirect fall in consecutive cycles. The bench checks the debug fetch address in the cycle the branch is in execute, and confirms that no skipped store fires.

// File: rtl/sixstage_pkg.sv
package sixstage_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned REG_AW  = 3;
  localparam int unsigned NUM_REG = 8;
  localparam int unsigned IMM_W   = 8;

  typedef enum logic [1:0] {
    OP_SUB = 2'b00,
    OP_BEQ = 2'b01,
    OP_LW  = 2'b10,
    OP_SW  = 2'b11
  } op_e;

  typedef logic [REG_AW-1:0] reg_idx_t;

  function automatic op_e op_of(logic [1:0] f);
    return op_e'(f);
  endfunction

  // destination register of an instruction, zero when nothing is written
  function automatic reg_idx_t dest_of(op_e op, reg_idx_t rt, reg_idx_t rd);
    case (op)
      OP_SUB:  return rd;
      OP_LW:   return rt;
      default: return '0;
    endcase
  endfunction

  function automatic logic reads_rt(op_e op);
    return op != OP_LW;
  endfunction
endpackage

// File: rtl/sixstage_regfile.sv
module sixstage_regfile
  import sixstage_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREGS  = NUM_REG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  reg_idx_t          wa,
  input  logic [DATA_W-1:0] wd,
  input  reg_idx_t          ra1,
  input  reg_idx_t          ra2,
  output logic [DATA_W-1:0] rd1,
  output logic [DATA_W-1:0] rd2
);
  logic [DATA_W-1:0] regs_q [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 1; i < NREGS; i++) begin
        if (we && (wa == REG_AW'(i))) regs_q[i] <= wd;
      end
    end
  end

  // write-through: a same-cycle write is visible to the read
  always_comb begin
    if (ra1 == '0)                 rd1 = '0;
    else if (we && (wa == ra1))    rd1 = wd;
    else                           rd1 = regs_q[ra1];
    if (ra2 == '0)                 rd2 = '0;
    else if (we && (wa == ra2))    rd2 = wd;
    else                           rd2 = regs_q[ra2];
  end

  // R7
  r0_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra1 == '0) |-> (rd1 == '0));

  // R5
  wr_visible_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa != '0 && ra2 == wa) |=> ($stable(ra2) && $past(we) && !we) |-> (rd2 == $past(wd)));
endmodule

// File: rtl/sixstage_hazard.sv
module sixstage_hazard
  import sixstage_pkg::*;
#(
  parameter int unsigned NPEND = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ir_v,
  input  reg_idx_t ir_rs,
  input  reg_idx_t ir_rt,
  input  logic     ir_use_rt,
  input  reg_idx_t pend_dst [NPEND],
  output logic     stall
);
  logic [NPEND-1:0] hit_rs, hit_rt;

  for (genvar g = 0; g < NPEND; g++) begin : g_pend
    assign hit_rs[g] = (ir_rs != '0) && (ir_rs == pend_dst[g]);
    assign hit_rt[g] = ir_use_rt && (ir_rt != '0) && (ir_rt == pend_dst[g]);
  end

  assign stall = ir_v && ((|hit_rs) || (|hit_rt));

  // R7
  no_r0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_rs == '0 && (ir_rt == '0 || !ir_use_rt)) |-> !stall);
endmodule

// File: rtl/sixstage_exec.sv
module sixstage_exec
  import sixstage_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PC_W   = 16
) (
  input  logic              valid,
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [IMM_W-1:0]  imm,
  input  logic [PC_W-1:0]   pc,
  output logic [DATA_W-1:0] result,
  output logic              taken,
  output logic [PC_W-1:0]   target
);
  logic [DATA_W-1:0] diff, addr;

  assign diff   = a - b;
  assign addr   = a + DATA_W'($signed(imm));
  assign result = (op == OP_SUB) ? diff : addr;
  assign taken  = valid && (op == OP_BEQ) && (diff == '0);
  assign target = pc + PC_W'(2) + PC_W'($signed(imm));
endmodule

// File: rtl/sixstage_core.sv
module sixstage_core
  import sixstage_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PC_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [PC_W-1:0]         imem_addr,
  input  logic [INSTR_W-1:0]      imem_rdata,
  output logic [DATA_W-1:0]       dmem_addr,
  output logic [DATA_W-1:0]       dmem_wdata,
  output logic                    dmem_we,
  input  logic [DATA_W-1:0]       dmem_rdata,
  output logic [PC_W-1:0]         dbg_pc,
  output logic [5:0]              dbg_stage_valid,
  output logic [6*INSTR_W-1:0]    dbg_stage_instr
);
  localparam int unsigned NPEND = 2;

  logic [PC_W-1:0]    pc_q, pc_d;
  logic               id_v_q, id_v_d, ir_v_q, ir_v_d, ex_v_q, ex_v_d, mem_v_q, mem_v_d, wb_v_q, wb_v_d;
  logic [INSTR_W-1:0] id_i_q, id_i_d, ir_i_q, ir_i_d, ex_i_q, ex_i_d, mem_i_q, mem_i_d, wb_i_q, wb_i_d;
  logic [PC_W-1:0]    id_pc_q, id_pc_d, ir_pc_q, ir_pc_d, ex_pc_q, ex_pc_d;
  logic [DATA_W-1:0]  ex_a_q, ex_a_d, ex_b_q, ex_b_d;
  logic [DATA_W-1:0]  mem_res_q, mem_res_d, mem_sd_q, mem_sd_d, wb_val_q, wb_val_d;

  op_e                ex_op, mem_op, wb_op;
  reg_idx_t           ex_dst, mem_dst, wb_dst;
  reg_idx_t           pend_dst [NPEND];
  logic               stall, front_adv, br_ahead, fetch_en;
  logic [PC_W-1:0]    fetch_addr;
  logic [DATA_W-1:0]  rf_rd1, rf_rd2, alu_res;
  logic               ex_taken;
  logic [PC_W-1:0]    ex_target;

  // stage decode
  assign ex_op   = op_of(ex_i_q[15:14]);
  assign mem_op  = op_of(mem_i_q[15:14]);
  assign wb_op   = op_of(wb_i_q[15:14]);
  assign ex_dst  = ex_v_q  ? dest_of(ex_op,  ex_i_q[10:8],  ex_i_q[7:5])  : '0;
  assign mem_dst = mem_v_q ? dest_of(mem_op, mem_i_q[10:8], mem_i_q[7:5]) : '0;
  assign wb_dst  = wb_v_q  ? dest_of(wb_op,  wb_i_q[10:8],  wb_i_q[7:5])  : '0;
  assign pend_dst[0] = ex_dst;
  assign pend_dst[1] = mem_dst;

  sixstage_hazard #(.NPEND(NPEND)) hazard_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ir_v      (ir_v_q),
    .ir_rs     (ir_i_q[13:11]),
    .ir_rt     (ir_i_q[10:8]),
    .ir_use_rt (reads_rt(op_of(ir_i_q[15:14]))),
    .pend_dst  (pend_dst),
    .stall     (stall)
  );

  sixstage_regfile #(.DATA_W(DATA_W)) regfile_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wb_dst != '0),
    .wa    (wb_dst),
    .wd    (wb_val_q),
    .ra1   (ir_i_q[13:11]),
    .ra2   (ir_i_q[10:8]),
    .rd1   (rf_rd1),
    .rd2   (rf_rd2)
  );

  sixstage_exec #(.DATA_W(DATA_W), .PC_W(PC_W)) exec_i (
    .valid  (ex_v_q),
    .op     (ex_op),
    .a      (ex_a_q),
    .b      (ex_b_q),
    .imm    (ex_i_q[7:0]),
    .pc     (ex_pc_q),
    .result (alu_res),
    .taken  (ex_taken),
    .target (ex_target)
  );

  // fetch control: no fetch while a branch sits in decode or operand read
  assign br_ahead   = (id_v_q && op_of(id_i_q[15:14]) == OP_BEQ) ||
                      (ir_v_q && op_of(ir_i_q[15:14]) == OP_BEQ);
  assign front_adv  = !stall;
  assign fetch_en   = front_adv && !br_ahead;
  assign fetch_addr = ex_taken ? ex_target : pc_q;
  assign imem_addr  = fetch_addr;

  // next-state
  always_comb begin
    pc_d    = fetch_en ? fetch_addr + PC_W'(2) : pc_q;
    id_v_d  = fetch_en;
    id_i_d  = fetch_en ? imem_rdata : '0;
    id_pc_d = fetch_addr;
    ir_v_d  = id_v_q;
    ir_i_d  = id_i_q;
    ir_pc_d = id_pc_q;
    if (front_adv) begin
      ex_v_d = ir_v_q;
      ex_i_d = ir_i_q;
      ex_a_d = rf_rd1;
      ex_b_d = rf_rd2;
    end else begin
      ex_v_d = 1'b0;
      ex_i_d = '0;
      ex_a_d = '0;
      ex_b_d = '0;
    end
    ex_pc_d   = ir_pc_q;
    mem_v_d   = ex_v_q;
    mem_i_d   = ex_i_q;
    mem_res_d = alu_res;
    mem_sd_d  = ex_b_q;
    wb_v_d    = mem_v_q;
    wb_i_d    = mem_i_q;
    wb_val_d  = (mem_op == OP_LW) ? dmem_rdata : mem_res_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      id_v_q <= 1'b0; id_i_q <= '0; id_pc_q <= '0;
      ir_v_q <= 1'b0; ir_i_q <= '0; ir_pc_q <= '0;
      ex_v_q <= 1'b0; ex_i_q <= '0; ex_pc_q <= '0; ex_a_q <= '0; ex_b_q <= '0;
      mem_v_q <= 1'b0; mem_i_q <= '0; mem_res_q <= '0; mem_sd_q <= '0;
      wb_v_q <= 1'b0; wb_i_q <= '0; wb_val_q <= '0;
    end else begin
      if (front_adv) begin
        pc_q    <= pc_d;
        id_v_q  <= id_v_d;
        id_i_q  <= id_i_d;
        id_pc_q <= id_pc_d;
        ir_v_q  <= ir_v_d;
        ir_i_q  <= ir_i_d;
        ir_pc_q <= ir_pc_d;
      end
      ex_v_q    <= ex_v_d;
      ex_i_q    <= ex_i_d;
      ex_pc_q   <= ex_pc_d;
      ex_a_q    <= ex_a_d;
      ex_b_q    <= ex_b_d;
      mem_v_q   <= mem_v_d;
      mem_i_q   <= mem_i_d;
      mem_res_q <= mem_res_d;
      mem_sd_q  <= mem_sd_d;
      wb_v_q    <= wb_v_d;
      wb_i_q    <= wb_i_d;
      wb_val_q  <= wb_val_d;
    end
  end

  // memory side and debug
  assign dmem_addr  = mem_res_q;
  assign dmem_wdata = mem_sd_q;
  assign dmem_we    = mem_v_q && (mem_op == OP_SW);

  assign dbg_pc          = fetch_addr;
  assign dbg_stage_valid = {wb_v_q, mem_v_q, ex_v_q, ir_v_q, id_v_q, fetch_en};
  assign dbg_stage_instr = {wb_i_q, mem_i_q, ex_i_q, ir_i_q, id_i_q,
                            (fetch_en ? imem_rdata : INSTR_W'(0))};

  // R5
  hold_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_v_q);

  // R5
  hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pc_q) && $stable(ir_i_q));

  // R8
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_taken |=> (id_v_q && id_pc_q == $past(ex_target)));

  // R8
  no_fetch_after_beq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_v_q && op_of(id_i_q[15:14]) == OP_BEQ && !stall) |=> !id_v_q);
endmodule

// File: tb/sixstage_core_tb.sv
`timescale 1ns/1ps
module sixstage_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr, imem_rdata;
  logic [15:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [15:0] dbg_pc;
  logic [5:0]  dbg_stage_valid;
  logic [95:0] dbg_stage_instr;

  logic [15:0] imem [32];
  logic [15:0] dmem [64];

  int cyc;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int wr_n;
  logic [15:0] wr_addr [16];
  logic [15:0] wr_data [16];
  int          wr_cyc  [16];

  always #2 clk = ~clk;

  sixstage_core dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .imem_addr       (imem_addr),
    .imem_rdata      (imem_rdata),
    .dmem_addr       (dmem_addr),
    .dmem_wdata      (dmem_wdata),
    .dmem_we         (dmem_we),
    .dmem_rdata      (dmem_rdata),
    .dbg_pc          (dbg_pc),
    .dbg_stage_valid (dbg_stage_valid),
    .dbg_stage_instr (dbg_stage_instr)
  );

  assign imem_rdata = imem[imem_addr[5:1]];
  assign dmem_rdata = dmem[dmem_addr[5:0]];

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
    if (rst_n && dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;
  end

  always @(negedge clk) begin
    if (rst_n && dmem_we && wr_n < 16) begin
      wr_addr[wr_n] = dmem_addr;
      wr_data[wr_n] = dmem_wdata;
      wr_cyc[wr_n]  = cyc;
      wr_n = wr_n + 1;
    end
  end

  function automatic logic [15:0] e_sub(int rd, int rs, int rt);
    return {2'b00, 3'(rs), 3'(rt), 3'(rd), 5'b0};
  endfunction
  function automatic logic [15:0] e_imm(logic [1:0] op, int rt, int rs, int imm);
    return {op, 3'(rs), 3'(rt), 8'(imm)};
  endfunction
  localparam logic [1:0] BEQ = 2'b01, LW = 2'b10, SW = 2'b11;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 32; i++) imem[i] = 16'h0000;
    for (int i = 0; i < 64; i++) dmem[i] = 16'h0000;
    dmem[1] = 16'd30;
    dmem[2] = 16'd12;
    dmem[3] = 16'd7;
  endtask

  task automatic start();
    rst_n = 1'b0;
    wr_n  = 0;
    @(negedge clk);
    @(negedge clk);
    chk(dbg_pc == 16'd0, "R9 reset pc", int'(dbg_pc), 0);
    chk(dbg_stage_valid[5:1] == 5'd0, "R9 reset stages empty", int'(dbg_stage_valid[5:1]), 0);
    chk(dmem_we == 1'b0, "R9 reset no store", int'(dmem_we), 0);
    rst_n = 1'b1;
  endtask

  task automatic expect_wr(int idx, int addr, int data, int c, string tag);
    chk(wr_n > idx, {tag, " store present"}, wr_n, idx + 1);
    if (wr_n > idx) begin
      chk(wr_addr[idx] == 16'(addr), {tag, " address"}, int'(wr_addr[idx]), addr);
      chk(wr_data[idx] == 16'(data), {tag, " data"}, int'(wr_data[idx]), data);
      chk(wr_cyc[idx] == c, {tag, " cycle"}, wr_cyc[idx], c);
    end
  endtask

  task automatic wait_cyc(int c);
    while (cyc != c) @(negedge clk);
  endtask

  // R2 R3 R4: independent loads and stores, negative offset
  task automatic t_basic();
    clear_mem();
    imem[0] = e_imm(LW, 1, 0, 1);
    imem[1] = e_imm(LW, 2, 0, 2);
    imem[4] = e_imm(SW, 1, 2, 16);
    imem[5] = e_imm(SW, 2, 1, 8'hFF);
    start();
    wait_cyc(2);
    chk(dbg_pc == 16'd4 && dbg_stage_valid == 6'b000111, "R4 R10 fetch address cycle 2",
        int'(dbg_pc), 4);
    repeat (20) @(negedge clk);
    expect_wr(0, 28, 30, 8, "R3 basic first");
    expect_wr(1, 29, 12, 9, "R2 basic negative offset");
    chk(wr_n == 2, "R4 basic store count", wr_n, 2);
  endtask

  // R1 R5: subtract waiting on two loads, then a store waiting on it
  task automatic t_sub();
    clear_mem();
    imem[0] = e_imm(LW, 1, 0, 1);
    imem[1] = e_imm(LW, 2, 0, 2);
    imem[2] = e_sub(3, 1, 2);
    imem[3] = e_imm(SW, 3, 0, 5);
    start();
    repeat (25) @(negedge clk);
    expect_wr(0, 5, 18, 11, "R1 R5 sub chain");
    chk(wr_n == 1, "R1 sub store count", wr_n, 1);
  endtask

  // R6 R5: store data register back to back
  task automatic t_store_data();
    clear_mem();
    imem[0] = e_imm(LW, 1, 0, 1);
    imem[1] = e_imm(SW, 1, 0, 20);
    imem[2] = e_imm(SW, 1, 0, 21);
    start();
    repeat (20) @(negedge clk);
    expect_wr(0, 20, 30, 7, "R6 store rt back-to-back");
    expect_wr(1, 21, 30, 8, "R5 follower of held store");
  endtask

  // R6 R5: store base register one slot behind
  task automatic t_store_base();
    clear_mem();
    imem[0] = e_imm(LW, 4, 0, 3);
    imem[2] = e_imm(SW, 4, 4, 1);
    start();
    repeat (20) @(negedge clk);
    expect_wr(0, 8, 7, 7, "R6 R5 store base one apart");
  endtask

  // R7: write to register 0 dropped, no hold
  task automatic t_r0();
    clear_mem();
    imem[0] = e_imm(LW, 1, 0, 1);
    imem[3] = e_sub(0, 1, 0);
    imem[4] = e_imm(SW, 0, 0, 9);
    imem[5] = e_imm(SW, 1, 0, 10);
    start();
    repeat (20) @(negedge clk);
    expect_wr(0, 9, 0, 8, "R7 r0 stays zero, no hold");
    expect_wr(1, 10, 30, 9, "R7 follower");
  endtask

  // R8 R10: taken branch
  task automatic t_taken();
    clear_mem();
    imem[0] = e_imm(BEQ, 0, 0, 4);
    imem[1] = e_imm(SW, 0, 0, 30);
    imem[2] = e_imm(SW, 0, 0, 31);
    imem[3] = e_imm(SW, 0, 0, 32);
    start();
    wait_cyc(2);
    chk(dbg_stage_valid[0] == 1'b0, "R8 no fetch with branch ahead", int'(dbg_stage_valid[0]), 0);
    wait_cyc(3);
    chk(dbg_pc == 16'd6, "R8 R10 taken redirect address", int'(dbg_pc), 6);
    repeat (20) @(negedge clk);
    expect_wr(0, 32, 0, 7, "R8 taken target store");
    chk(wr_n == 1, "R8 skipped stores absent", wr_n, 1);
  endtask

  // R8 R5: not-taken branch on a just-loaded register
  task automatic t_not_taken();
    clear_mem();
    imem[0] = e_imm(LW, 1, 0, 1);
    imem[1] = e_imm(BEQ, 0, 1, 4);
    imem[2] = e_imm(SW, 1, 0, 33);
    start();
    wait_cyc(6);
    chk(dbg_pc == 16'd4 && dbg_stage_valid[0], "R8 fall-through fetch cycle 6", int'(dbg_pc), 4);
    repeat (20) @(negedge clk);
    expect_wr(0, 33, 30, 10, "R8 not-taken store");
    chk(wr_n == 1, "R8 not-taken store count", wr_n, 1);
  endtask

  initial begin
    t_basic();
    t_sub();
    t_store_data();
    t_store_base();
    t_r0();
    t_taken();
    t_not_taken();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule